// File: doc/BRIEF.md
# Event Counter Bank

A bank of wide event counters for a chip-level performance monitor. Upstream logic delivers a vector of single-cycle event pulses, one bit per event number. Each counter picks one event number through an 8-bit code and advances by one on every clock in which that pulse is high. Counting needs both the counter's own enable bit and a shared run bit.

A small word-wide register bus configures and reads the bank. Software writes the codes, enables, run bit and interrupt mask. It reads or preloads each counter through two word halves. When a counter rolls over from all ones to zero, a sticky overflow flag is raised for it. An interrupt line reports the flags that software has not masked. Software clears the flags by writing ones to a separate clear register.

Top module: `evt_count_bank`

## Requirements
- R1: After reset, every counter, the run bit, all enable bits, all event codes and all overflow flags are zero. All mask bits are one and `irq` is low.
- R2: The registers are at fixed word addresses: mask 0x0814, flags 0x0818, flag clear 0x081c, run control 0x1c00 (bit 0), counter enables 0x1c14 (bit n for counter n), code registers 0x1c18 and 0x1c1c, identity word 0x1cf0, and counter n low word at 0x1d00+8n with its high word at 0x1d04+8n.
- R3: While the run bit is 0, no counter changes except through a bus write.
- R4: A counter whose enable bit is 0 never advances.
- R5: Counter n takes its code from byte lane n mod 4 (bits 8*(n mod 4) upward) of code register n/4. Code 0x09 counts every clock. A code of 0x80 or above never counts. Any other code counts the matching bit of `evt_pulse`.
- R6: An enabled counter gains exactly one for each clock edge at which the run bit is set and its selected event is high.
- R7: When a counter steps from all ones to zero, its flag bit is set at the same edge. A flag stays set until it is cleared.
- R8: Writing 1 to bit n of the clear register clears flag n. Writing 0 has no effect, and writes to the flag register itself are ignored.
- R9: `irq` is high exactly when some flag is set whose mask bit is 0.
- R10: A bus write to one half of a counter replaces only that half. In a cycle that has both a write and a count, the write wins and the count is dropped.
- R11: Read data appears on `bus_rdata` one clock after `bus_rd`, and it holds until the next read.
- R12: The identity word reads back the `VERSION_ID` parameter, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 128 | Event pulses, bit k is event number k |
| irq | output | 1 | Overflow interrupt, level |

## Verification
A write takes effect at the clock edge on which the strobe is sampled. Counting then begins at the next edge, so a run bit held for k idle cycles between its set and clear writes yields k+1 counts. Read data is due one edge after the read strobe. The scoreboard monitor therefore compares each queued expectation at the falling edge that follows that edge. The overflow flag and the unregistered `irq` are due at the same edge as the wrap or the mask write, so they are checked at the falling edge immediately after it.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
   localparam int unsigned ADDR_W = 16;
   typedef logic [ADDR_W-1:0] ecb_addr_t;

   // word addresses decoded by the bank
   localparam ecb_addr_t A_IRQ_MASK = 16'h0814;
   localparam ecb_addr_t A_IRQ_STAT = 16'h0818;
   localparam ecb_addr_t A_IRQ_CLR  = 16'h081c;
   localparam ecb_addr_t A_RUN_CTRL = 16'h1c00;
   localparam ecb_addr_t A_CNT_EN   = 16'h1c14;
   localparam ecb_addr_t A_SEL_BASE = 16'h1c18;
   localparam ecb_addr_t A_VERSION  = 16'h1cf0;
   localparam ecb_addr_t A_CNT_BASE = 16'h1d00;

   // code that counts every clock
   localparam logic [7:0] CYCLE_CODE = 8'h09;
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter
   import ecb_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned EVT_NUM = 128
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               count_on,
   input  logic [EVT_NUM-1:0] evt_pulse,
   input  logic [CODE_W-1:0]  code,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [DATA_W-1:0]  wdata,
   output logic [CNT_W-1:0]   value,
   output logic               wrap
);
   localparam int unsigned EW = $clog2(EVT_NUM);

   logic evt_sel;
   logic step;

   always_comb begin
      if (code == CODE_W'(CYCLE_CODE))
         evt_sel = 1'b1;
      else if (32'(code) < EVT_NUM)
         evt_sel = evt_pulse[code[EW-1:0]];
      else
         evt_sel = 1'b0;
   end

   // a bus write to either half suppresses the increment
   assign step = count_on & evt_sel & ~(wr_lo | wr_hi);
   assign wrap = step & (&value);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value <= '0;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) value[DATA_W-1:0]     <= wdata;
         if (wr_hi) value[CNT_W-1:DATA_W] <= wdata;
      end else if (step) begin
         value <= value + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ecb_irq.sv
module ecb_irq #(
   parameter int unsigned NUM      = 8,
   parameter bit          IRQ_FLOP = 1'b0
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] ovf,
   input  logic           clr_we,
   input  logic           mask_we,
   input  logic [NUM-1:0] wdata,
   output logic [NUM-1:0] status,
   output logic [NUM-1:0] mask,
   output logic           irq
);
   logic irq_raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '1;
      end else begin
         if (mask_we) mask <= wdata;
         // a new overflow wins over a clear in the same cycle
         status <= (status & ~(clr_we ? wdata : NUM'(0))) | ovf;
      end
   end

   assign irq_raw = |(status & ~mask);

   if (IRQ_FLOP) begin : g_irq_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end
endmodule

// File: rtl/evt_count_bank.sv
module evt_count_bank
   import ecb_pkg::*;
#(
   parameter int unsigned     NUM_CNT    = 8,
   parameter int unsigned     CNT_W      = 64,
   parameter int unsigned     DATA_W     = 32,
   parameter int unsigned     CODE_W     = 8,
   parameter int unsigned     EVT_NUM    = 128,
   parameter logic [DATA_W-1:0] VERSION_ID = 32'h0001_0000,
   parameter bit              IRQ_FLOP   = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [EVT_NUM-1:0] evt_pulse,
   output logic               irq
);
   localparam int unsigned LANES    = DATA_W / CODE_W;
   localparam int unsigned SEL_REGS = NUM_CNT / LANES;
   localparam int unsigned SEL_IW   = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1;
   localparam int unsigned IDX_W    = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
   localparam int unsigned CNT_SPAN = NUM_CNT * 8;
   localparam int unsigned SEL_SPAN = SEL_REGS * 4;

   // elaboration-time parameter checks
   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must be twice DATA_W");
   end
   if (DATA_W != 32) begin : g_bad_data_w
      $error("counter stride assumes 32-bit words");
   end
   if (NUM_CNT > DATA_W || NUM_CNT < 2) begin : g_bad_num
      $error("NUM_CNT must fit in one word");
   end
   if ((DATA_W % CODE_W) != 0 || (NUM_CNT % LANES) != 0) begin : g_bad_lanes
      $error("codes must pack evenly into select words");
   end
   if (EVT_NUM > (1 << CODE_W)) begin : g_bad_evt
      $error("EVT_NUM exceeds code range");
   end

   logic                              run_en;
   logic [NUM_CNT-1:0]                cnt_en;
   logic [NUM_CNT-1:0][CODE_W-1:0]    code;
   logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_val;
   logic [NUM_CNT-1:0]                ovf;
   logic [NUM_CNT-1:0]                status;
   logic [NUM_CNT-1:0]                mask;
   logic [DATA_W-1:0]                 rd_mux;

   // address decode
   logic [ADDR_W-1:0] cnt_off;
   logic [ADDR_W-1:0] sel_off;
   logic              cnt_hit;
   logic              cnt_upper;
   logic [IDX_W-1:0]  cnt_idx;
   logic              sel_hit;
   logic [SEL_IW-1:0] sel_idx;

   assign cnt_off   = bus_addr - A_CNT_BASE;
   assign cnt_hit   = (bus_addr >= A_CNT_BASE) && (cnt_off < ADDR_W'(CNT_SPAN))
                      && (bus_addr[1:0] == 2'b00);
   assign cnt_idx   = cnt_off[IDX_W+2:3];
   assign cnt_upper = cnt_off[2];

   assign sel_off   = bus_addr - A_SEL_BASE;
   assign sel_hit   = (bus_addr >= A_SEL_BASE) && (sel_off < ADDR_W'(SEL_SPAN))
                      && (bus_addr[1:0] == 2'b00);
   assign sel_idx   = sel_off[SEL_IW+1:2];

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en <= 1'b0;
         cnt_en <= '0;
         code   <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_RUN_CTRL) run_en <= bus_wdata[0];
         if (bus_addr == A_CNT_EN)   cnt_en <= bus_wdata[NUM_CNT-1:0];
         for (int n = 0; n < NUM_CNT; n++) begin
            if (sel_hit && sel_idx == SEL_IW'(n / LANES))
               code[n] <= bus_wdata[(n % LANES)*CODE_W +: CODE_W];
         end
      end
   end

   // counters
   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      ecb_counter #(
         .CNT_W   (CNT_W),
         .DATA_W  (DATA_W),
         .CODE_W  (CODE_W),
         .EVT_NUM (EVT_NUM)
      ) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .count_on  (run_en & cnt_en[g]),
         .evt_pulse (evt_pulse),
         .code      (code[g]),
         .wr_lo     (bus_wr & cnt_hit & (cnt_idx == IDX_W'(g)) & ~cnt_upper),
         .wr_hi     (bus_wr & cnt_hit & (cnt_idx == IDX_W'(g)) & cnt_upper),
         .wdata     (bus_wdata),
         .value     (cnt_val[g]),
         .wrap      (ovf[g])
      );
   end

   ecb_irq #(
      .NUM      (NUM_CNT),
      .IRQ_FLOP (IRQ_FLOP)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ovf     (ovf),
      .clr_we  (bus_wr && bus_addr == A_IRQ_CLR),
      .mask_we (bus_wr && bus_addr == A_IRQ_MASK),
      .wdata   (bus_wdata[NUM_CNT-1:0]),
      .status  (status),
      .mask    (mask),
      .irq     (irq)
   );

   // read path
   always_comb begin
      rd_mux = '0;
      if (cnt_hit) begin
         rd_mux = cnt_upper ? cnt_val[cnt_idx][CNT_W-1:DATA_W]
                            : cnt_val[cnt_idx][DATA_W-1:0];
      end else if (sel_hit) begin
         for (int n = 0; n < NUM_CNT; n++) begin
            if (sel_idx == SEL_IW'(n / LANES))
               rd_mux[(n % LANES)*CODE_W +: CODE_W] = code[n];
         end
      end else begin
         case (bus_addr)
            A_RUN_CTRL: rd_mux = DATA_W'(run_en);
            A_CNT_EN:   rd_mux = DATA_W'(cnt_en);
            A_IRQ_MASK: rd_mux = DATA_W'(mask);
            A_IRQ_STAT: rd_mux = DATA_W'(status);
            A_VERSION:  rd_mux = VERSION_ID;
            default:    rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker
   import ecb_pkg::*;
#(
   parameter int unsigned NUM_CNT = 8,
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned DATA_W  = 32
)(
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_wr,
   input logic                          bus_rd,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [DATA_W-1:0]             bus_rdata,
   input logic                          run_en,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val,
   input logic [NUM_CNT-1:0]            status,
   input logic [NUM_CNT-1:0]            mask,
   input logic                          irq
);
   // R3: no counting while stopped and the bus is quiet
   a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !bus_wr) |=> $stable(cnt_val));

   // R7: flags are sticky unless the clear register is written
   a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_IRQ_CLR) |=> ((status & $past(status)) == $past(status)));

   // R9: the interrupt needs a set flag whose mask bit is open
   a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((status & ~mask) != '0 || ($past(status) & ~$past(mask)) != '0));

   // R11: read data only moves on a read
   a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind evt_count_bank ecb_checker #(
   .NUM_CNT (NUM_CNT),
   .CNT_W   (CNT_W),
   .DATA_W  (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .run_en    (run_en),
   .cnt_val   (cnt_val),
   .status    (status),
   .mask      (mask),
   .irq       (irq)
);

// File: tb/evt_count_bank_tb_top.sv
`timescale 1ns/1ps
module evt_count_bank_tb_top;
   localparam logic [31:0] VER = 32'h5A3C_0102;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [15:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [127:0] evt_pulse = '0;
   logic         irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #2 clk = ~clk;

   evt_count_bank #(.VERSION_ID(VER)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_pulse (evt_pulse),
      .irq       (irq)
   );

   // monitor: compare read data one edge after the strobe
   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (bus_rdata !== e) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", t, bus_rdata, e);
         end
      end
   end

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", t, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 irq after reset", 32'(irq), 32'h0);
      rd(16'h1c00, 32'h0, "R1 run bit");
      rd(16'h1c14, 32'h0, "R1 enables");
      rd(16'h0814, 32'h0000_00FF, "R1 mask all ones");
      rd(16'h0818, 32'h0, "R1 flags");
      rd(16'h1d00, 32'h0, "R1 counter0 low");
      rd(16'h1d3c, 32'h0, "R1 counter7 high");
      rd(16'h1c18, 32'h0, "R1 codes");

      // R6 cycle code: counter0 lane0=0x09, counter1 lane1=0x09 but disabled
      wr(16'h1c18, 32'h0000_0909);
      wr(16'h1c14, 32'h0000_0001);
      wr(16'h1c00, 32'h1);
      idle(4);
      wr(16'h1c00, 32'h0);
      rd(16'h1d00, 32'd5, "R6 cycle count five");
      rd(16'h1d08, 32'd0, "R4 disabled counter1");
      // R3 stopped: nothing moves
      idle(5);
      rd(16'h1d00, 32'd5, "R3 held while stopped");

      // R5 lanes: counter4 code 0x30, counter5 code 0x85 (invalid)
      wr(16'h1c1c, 32'h0000_8530);
      rd(16'h1c1c, 32'h0000_8530, "R5 code readback");
      wr(16'h1c14, 32'h0000_0031);
      evt_pulse[8'h30] = 1'b1;
      evt_pulse[8'h05] = 1'b1;
      wr(16'h1c00, 32'h1);
      idle(2);
      wr(16'h1c00, 32'h0);
      evt_pulse = '0;
      rd(16'h1d20, 32'd3, "R5 event 0x30 counter4");
      rd(16'h1d28, 32'd0, "R5 invalid code counter5");
      rd(16'h1d00, 32'd8, "R6 counter0 kept counting");

      // R10 high half only
      wr(16'h1d24, 32'h1234_5678);
      rd(16'h1d24, 32'h1234_5678, "R10 high half write");
      rd(16'h1d20, 32'd3, "R10 low half untouched");

      // R7 wrap on counter2
      wr(16'h1c18, 32'h0009_0909);
      wr(16'h1c14, 32'h0000_0004);
      wr(16'h1d14, 32'hFFFF_FFFF);
      wr(16'h1d10, 32'hFFFF_FFFE);
      wr(16'h1c00, 32'h1);
      idle(1);
      wr(16'h1c00, 32'h0);
      chk("R9 masked flag keeps irq low", 32'(irq), 32'h0);
      rd(16'h0818, 32'h0000_0004, "R7 flag set on wrap");
      rd(16'h1d10, 32'h0, "R7 wrapped low");
      rd(16'h1d14, 32'h0, "R7 wrapped high");
      wr(16'h0814, 32'h0000_00FB);
      chk("R9 unmasked flag raises irq", 32'(irq), 32'h1);
      rd(16'h0814, 32'h0000_00FB, "R2 mask readback");

      // R10 write wins over a same-cycle count
      wr(16'h1c00, 32'h1);
      wr(16'h1d10, 32'h0000_0100);
      wr(16'h1c00, 32'h0);
      rd(16'h1d10, 32'h0000_0101, "R10 write beats increment");

      // R8 clearing rules
      wr(16'h081c, 32'h0);
      rd(16'h0818, 32'h0000_0004, "R8 zero clear no effect");
      wr(16'h0818, 32'h0);
      rd(16'h0818, 32'h0000_0004, "R8 flag register write ignored");
      chk("R7 flag still drives irq", 32'(irq), 32'h1);
      wr(16'h081c, 32'h0000_0004);
      chk("R9 irq low after clear", 32'(irq), 32'h0);
      rd(16'h0818, 32'h0, "R8 flag cleared");

      // R12 identity and R11 hold
      wr(16'h1cf0, 32'h0);
      rd(16'h1cf0, VER, "R12 identity word");
      idle(3);
      chk("R11 read data holds", bus_rdata, VER);
      rd(16'h1d00, 32'd8, "R4 counter0 idle when disabled");

      idle(2);
      chk("R11 all reads answered", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end
endmodule